// File: doc/BRIEF.md
# Multi-Queue Blocking Synchronization Array

This block carries data words between producer threads and consumer threads that run as stages of a software pipeline. It holds a fixed number of independent first-in first-out queues in one shared storage array. Each request names its queue with a small index, the dependence number. A producer pushes a word into the named queue. A consumer pops the oldest word from the named queue. Neither side needs to know anything about the other.

Both ports use a valid/ready handshake. A request that cannot complete is not dropped. A produce aimed at a full queue, or a consume aimed at an empty one, raises a stall output toward the requesting thread. The requester keeps the request asserted, with the same index and data, until the block accepts it.

Acceptance depends only on the occupancy registered at the start of the cycle. Because of this, a word pushed into an empty queue can be consumed in the next cycle at the earliest. Every queue has its own read pointer, write pointer and occupancy count.

Top module: `mqsa_sync_array`

## Requirements
- R1: Each of the 8 queues, selected by the 3-bit index value 0 to 7, is independent. Words pushed to one queue never appear when another queue is consumed.
- R2: `prod_ready` is high whenever the queue selected by `prod_qid` holds fewer than 4 words. A cycle with `prod_valid` and `prod_ready` both high appends `prod_data` to that queue.
- R3: A produce to a full queue is not accepted: `prod_ready` is low and the queue is unchanged. The produce is accepted in the first cycle that begins with a free slot.
- R4: In a cycle where `cons_valid` and `cons_ready` are both high, `cons_data` carries the oldest word of the queue selected by `cons_qid`, and that word is removed. Words leave each queue in the order they were pushed.
- R5: `cons_ready` is low while the selected queue is empty, so a consume from an empty queue is held off.
- R6: A produce and a consume to the same queue in the same cycle are both accepted when that queue holds between 1 and 3 words.
- R7: A produce and a consume to the same empty queue in the same cycle: the produce is accepted, the consume stalls, and the held consume is accepted in the next cycle with the pushed word.
- R8: A produce and a consume to the same full queue in the same cycle: the consume is accepted, the produce stalls, and the held produce is accepted in the next cycle.
- R9: Reset, at start-up or in mid-run, empties all 8 queues.
- R10: `prod_stall` equals `prod_valid` and not `prod_ready`. `cons_stall` equals `cons_valid` and not `cons_ready`. No stall is raised without a request.
- R11: Each queue holds up to 4 words at the same time as every other queue. Filling one queue does not reduce the space left in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_valid | input | 1 | Produce request present |
| prod_qid | input | 3 | Queue index of the produce request |
| prod_data | input | 32 | Word to append |
| prod_ready | output | 1 | Selected produce queue has a free slot |
| prod_stall | output | 1 | Produce request is being held off |
| cons_valid | input | 1 | Consume request present |
| cons_qid | input | 3 | Queue index of the consume request |
| cons_ready | output | 1 | Selected consume queue holds data |
| cons_data | output | 32 | Oldest word of the selected consume queue |
| cons_stall | output | 1 | Consume request is being held off |

## Verification
A produce and a consume can land in the same cycle, and the hard case is when both target the same queue. The directed part of the bench sets up this collision with the target queue empty, then partly filled, then full. In each case it checks which side is accepted, which side stalls, and that the held side is accepted one cycle later with the right word. The random phase draws both indices from a small range so that such collisions keep recurring. A behavioural model built on queues predicts both ready outputs, both stall outputs and the consumed word in every cycle.

// File: rtl/mqsa_pkg.sv
package mqsa_pkg;

  // Fullness flags of one queue, as seen by the handshake logic.
  typedef struct packed {
    logic full;
    logic empty;
  } q_flags_t;

endpackage

// File: rtl/mqsa_queue_ctrl.sv
module mqsa_queue_ctrl #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output mqsa_pkg::q_flags_t flags
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign upd_en = push | pop;

  // Next-state logic
  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) begin
      wptr_d = (wptr_q == LAST_SLOT) ? '0 : wptr_q + 1'b1;
    end
    if (pop) begin
      rptr_d = (rptr_q == LAST_SLOT) ? '0 : rptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wptr        = wptr_q;
  assign rptr        = rptr_q;
  assign flags.full  = (cnt_q == CNT_FULL);
  assign flags.empty = (cnt_q == '0);

endmodule

// File: rtl/mqsa_storage.sv
module mqsa_storage #(
  parameter int DATA_W = 32,
  parameter int NUM_Q  = 8,
  parameter int DEPTH  = 4,
  parameter int QIDX_W = 3,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [QIDX_W-1:0] wr_q,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [QIDX_W-1:0] rd_q,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WORDS  = NUM_Q * DEPTH;
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] mem [WORDS];

  // Each queue owns a contiguous slice of DEPTH words.
  assign wr_addr = ADDR_W'(ADDR_W'(wr_q) * ADDR_W'(DEPTH) + ADDR_W'(wr_ptr));
  assign rd_addr = ADDR_W'(ADDR_W'(rd_q) * ADDR_W'(DEPTH) + ADDR_W'(rd_ptr));

  // One enabled register per word; data words carry no reset.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic word_we;
    assign word_we = wr_en && (wr_addr == ADDR_W'(w));
    always_ff @(posedge clk) begin
      if (word_we) begin
        mem[w] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mqsa_handshake.sv
module mqsa_handshake #(
  parameter int NUM_Q  = 8,
  parameter int QIDX_W = 3
) (
  input  logic                          prod_valid,
  input  logic [QIDX_W-1:0]             prod_qid,
  input  logic                          cons_valid,
  input  logic [QIDX_W-1:0]             cons_qid,
  input  mqsa_pkg::q_flags_t [NUM_Q-1:0] flags,
  output logic                          prod_ready,
  output logic                          prod_stall,
  output logic                          cons_ready,
  output logic                          cons_stall,
  output logic [NUM_Q-1:0]              push_vec,
  output logic [NUM_Q-1:0]              pop_vec
);

  logic prod_go;
  logic cons_go;

  // Readiness depends only on registered flags: a word pushed into an
  // empty queue becomes visible to the consumer one cycle later.
  assign prod_ready = !flags[prod_qid].full;
  assign cons_ready = !flags[cons_qid].empty;
  assign prod_stall = prod_valid && !prod_ready;
  assign cons_stall = cons_valid && !cons_ready;
  assign prod_go    = prod_valid && prod_ready;
  assign cons_go    = cons_valid && cons_ready;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_dec
    assign push_vec[i] = prod_go && (prod_qid == QIDX_W'(i));
    assign pop_vec[i]  = cons_go && (cons_qid == QIDX_W'(i));
  end

endmodule

// File: rtl/mqsa_sync_array.sv
module mqsa_sync_array #(
  parameter int NUM_Q  = 8,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int QIDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_valid,
  input  logic [QIDX_W-1:0] prod_qid,
  input  logic [DATA_W-1:0] prod_data,
  output logic              prod_ready,
  output logic              prod_stall,
  input  logic              cons_valid,
  input  logic [QIDX_W-1:0] cons_qid,
  output logic              cons_ready,
  output logic [DATA_W-1:0] cons_data,
  output logic              cons_stall
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  mqsa_pkg::q_flags_t [NUM_Q-1:0] flags;
  logic [NUM_Q-1:0][PTR_W-1:0]    wptr_all;
  logic [NUM_Q-1:0][PTR_W-1:0]    rptr_all;
  logic [NUM_Q-1:0]               push_vec;
  logic [NUM_Q-1:0]               pop_vec;
  logic                           wr_en;

  mqsa_handshake #(
    .NUM_Q  (NUM_Q),
    .QIDX_W (QIDX_W)
  ) u_hs (
    .prod_valid (prod_valid),
    .prod_qid   (prod_qid),
    .cons_valid (cons_valid),
    .cons_qid   (cons_qid),
    .flags      (flags),
    .prod_ready (prod_ready),
    .prod_stall (prod_stall),
    .cons_ready (cons_ready),
    .cons_stall (cons_stall),
    .push_vec   (push_vec),
    .pop_vec    (pop_vec)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    mqsa_queue_ctrl #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W),
      .CNT_W (CNT_W)
    ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_vec[q]),
      .pop   (pop_vec[q]),
      .wptr  (wptr_all[q]),
      .rptr  (rptr_all[q]),
      .flags (flags[q])
    );
  end

  assign wr_en = |push_vec;

  mqsa_storage #(
    .DATA_W (DATA_W),
    .NUM_Q  (NUM_Q),
    .DEPTH  (DEPTH),
    .QIDX_W (QIDX_W),
    .PTR_W  (PTR_W)
  ) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_q    (prod_qid),
    .wr_ptr  (wptr_all[prod_qid]),
    .wr_data (prod_data),
    .rd_q    (cons_qid),
    .rd_ptr  (rptr_all[cons_qid]),
    .rd_data (cons_data)
  );

endmodule

// File: rtl/mqsa_checker.sv
module mqsa_checker #(
  parameter int NUM_Q  = 8,
  parameter int DEPTH  = 4,
  parameter int QIDX_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prod_valid,
  input logic [QIDX_W-1:0] prod_qid,
  input logic              prod_ready,
  input logic              prod_stall,
  input logic              cons_valid,
  input logic [QIDX_W-1:0] cons_qid,
  input logic              cons_ready,
  input logic              cons_stall
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // Occupancy seen from the ports only: accepted pushes minus accepted pops.
  logic [NUM_Q-1:0][CNT_W-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      for (int q = 0; q < NUM_Q; q++) begin
        if ((prod_valid && prod_ready && prod_qid == QIDX_W'(q)) &&
            !(cons_valid && cons_ready && cons_qid == QIDX_W'(q))) begin
          occ[q] <= occ[q] + 1'b1;
        end else if (!(prod_valid && prod_ready && prod_qid == QIDX_W'(q)) &&
                     (cons_valid && cons_ready && cons_qid == QIDX_W'(q))) begin
          occ[q] <= occ[q] - 1'b1;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && prod_ready) |-> (occ[prod_qid] < CNT_W'(DEPTH))); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && occ[prod_qid] == CNT_W'(DEPTH)) |-> prod_stall); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && cons_ready) |-> (occ[cons_qid] != '0)); // R4
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && occ[cons_qid] == '0) |-> cons_stall); // R5
  AST_SAME_Q_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && cons_valid && prod_qid == cons_qid &&
     occ[prod_qid] != '0 && occ[prod_qid] != CNT_W'(DEPTH))
    |-> (prod_ready && cons_ready)); // R6
  AST_EMPTY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && cons_valid && prod_qid == cons_qid && occ[prod_qid] == '0)
    |=> (cons_valid && cons_qid == $past(cons_qid)) |-> cons_ready); // R7
  AST_PROD_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_valid |-> !prod_stall); // R10
  AST_CONS_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_valid |-> !cons_stall); // R10

endmodule

bind mqsa_sync_array mqsa_checker #(
  .NUM_Q  (NUM_Q),
  .DEPTH  (DEPTH),
  .QIDX_W (QIDX_W)
) u_mqsa_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .prod_valid (prod_valid),
  .prod_qid   (prod_qid),
  .prod_ready (prod_ready),
  .prod_stall (prod_stall),
  .cons_valid (cons_valid),
  .cons_qid   (cons_qid),
  .cons_ready (cons_ready),
  .cons_stall (cons_stall)
);

// File: tb/mqsa_sync_array_bench.sv
module mqsa_sync_array_bench;

  localparam int NQ = 8;
  localparam int DP = 4;

  logic        clk;
  logic        rst_n;
  logic        prod_valid;
  logic [2:0]  prod_qid;
  logic [31:0] prod_data;
  logic        prod_ready;
  logic        prod_stall;
  logic        cons_valid;
  logic [2:0]  cons_qid;
  logic        cons_ready;
  logic [31:0] cons_data;
  logic        cons_stall;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] mq [NQ][$];

  mqsa_sync_array u_mqsa_sync_array (
    .clk (clk), .rst_n (rst_n),
    .prod_valid (prod_valid), .prod_qid (prod_qid), .prod_data (prod_data),
    .prod_ready (prod_ready), .prod_stall (prod_stall),
    .cons_valid (cons_valid), .cons_qid (cons_qid),
    .cons_ready (cons_ready), .cons_data (cons_data), .cons_stall (cons_stall)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int q = 0; q < NQ; q++) mq[q].delete();
  endtask

  // One clock: drive at the falling edge, compare against the model,
  // then advance the model to the state after the next rising edge.
  task automatic step(input bit pv, input logic [2:0] pq, input logic [31:0] pd,
                      input bit cv, input logic [2:0] cq, input string ph,
                      output bit p_acc, output bit c_acc);
    bit er_p, er_c;
    @(negedge clk);
    prod_valid = pv; prod_qid = pq; prod_data = pd;
    cons_valid = cv; cons_qid = cq;
    #2;
    er_p = (mq[pq].size() < DP);
    er_c = (mq[cq].size() != 0);
    chk({ph, "/", er_p ? "R2" : "R3", " prod_ready"}, 32'(prod_ready), 32'(er_p));
    chk({ph, "/", er_c ? "R4" : "R5", " cons_ready"}, 32'(cons_ready), 32'(er_c));
    chk({ph, "/R10 prod_stall"}, 32'(prod_stall), 32'(pv && !er_p));
    chk({ph, "/R10 cons_stall"}, 32'(cons_stall), 32'(cv && !er_c));
    p_acc = pv && er_p;
    c_acc = cv && er_c;
    if (c_acc) begin
      chk({ph, "/R4 cons_data"}, cons_data, mq[cq][0]);
      void'(mq[cq].pop_front());
    end
    if (p_acc) mq[pq].push_back(pd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    prod_valid = 1'b0; cons_valid = 1'b0;
    rst_n = 1'b0;
    clear_model();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    bit pa, ca;
    bit ppend, cpend;
    logic [2:0] rpq, rcq;
    logic [31:0] rpd;
    rst_n = 1'b0;
    prod_valid = 1'b0; prod_qid = '0; prod_data = '0;
    cons_valid = 1'b0; cons_qid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: every queue is empty after reset, so each consume stalls
    for (int q = 0; q < NQ; q++) step(0, 3'(q), 0, 1, 3'(q), "R9", pa, ca);

    // R11 and R1: fill queue 3 completely and queue 5 partly
    for (int i = 0; i < DP; i++) step(1, 3'd3, 32'h3000 + i, 0, 0, "R11", pa, ca);
    for (int i = 0; i < 2; i++)  step(1, 3'd5, 32'h5000 + i, 0, 0, "R11", pa, ca);
    // R3: produce into full queue 3 stalls and is held for two cycles
    step(1, 3'd3, 32'h3FFF, 0, 0, "R3", pa, ca);
    step(1, 3'd3, 32'h3FFF, 0, 0, "R3", pa, ca);
    // R1 and R4: queue 5 returns its own words in order
    step(0, 0, 0, 1, 3'd5, "R1", pa, ca);
    // R8: consume and produce hit full queue 3 together
    step(1, 3'd3, 32'h3FFF, 1, 3'd3, "R8", pa, ca);
    step(1, 3'd3, 32'h3FFF, 0, 0, "R8", pa, ca);
    // R6: queue 3 partly full, both sides at once
    step(0, 0, 0, 1, 3'd3, "R6", pa, ca);
    step(1, 3'd3, 32'h3ABC, 1, 3'd3, "R6", pa, ca);
    // R7: empty queue 0, both sides together, then held consume
    step(1, 3'd0, 32'h0000_00A7, 1, 3'd0, "R7", pa, ca);
    step(0, 0, 0, 1, 3'd0, "R7", pa, ca);
    // R4: drain remaining words in order
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 3'd3, "R4", pa, ca);
    step(0, 0, 0, 1, 3'd5, "R4", pa, ca);
    step(0, 0, 0, 1, 3'd5, "R5", pa, ca);

    // R9: mid-run reset after filling several queues
    for (int i = 0; i < 3; i++) step(1, 3'(i), 32'hC0DE_0000 + i, 0, 0, "R9", pa, ca);
    step(1, 3'd7, 32'h7777_0001, 0, 0, "R9", pa, ca);
    do_reset();
    for (int q = 0; q < NQ; q++) step(0, 3'(q), 0, 1, 3'(q), "R9", pa, ca);

    // Random traffic with held requests; indices drawn from 0..3 to collide
    ppend = 0; cpend = 0; rpq = '0; rcq = '0; rpd = '0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (!ppend) begin
        ppend = ($urandom % 3) != 0;
        rpq = 3'($urandom % 4);
        rpd = $urandom;
      end
      if (!cpend) begin
        cpend = ($urandom % 3) != 0;
        rcq = 3'($urandom % 4);
      end
      step(ppend, rpq, rpd, cpend, rcq, "R1", pa, ca);
      if (pa) ppend = 0;
      if (ca) cpend = 0;
    end

    @(negedge clk);
    prod_valid = 1'b0; cons_valid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule